// File: doc/BRIEF.md
# Timestamped Sampling Port Buffer

This block is a one-message mailbox for control data passed between partitions or end systems. A producer streams a message into it one byte per cycle and marks the final byte. When that final byte is accepted, the message becomes the current one. It carries its byte count and the value of a free-running time counter taken in that cycle. An arriving message is never refused. It simply replaces the one held before.

A consumer pulses a read strobe whenever it wants the latest value. One cycle later the block presents the whole payload, the byte count and the stored time stamp, together with a freshness flag. Reading does not consume anything, so the same message can be fetched as often as needed. The freshness flag compares the age of the held message with a refresh period supplied on an input. Age is measured in counter ticks and computed modulo the counter width, so it stays correct across a counter wrap.

Incoming bytes go into a second storage bank that readers never see. The banks trade roles only when a message is complete. A read therefore always returns one whole message, never a mixture of an old and a new one.

Top module: `sampling_port_buf`

## Requirements
- R1: After reset `rd_valid` is low, and a read made before any message has completed returns `rd_len` = 0, `rd_ts` = 0 and `rd_fresh` = 0.
- R2: A read strobe sampled on a clock edge makes `rd_valid` high for exactly the following cycle. `rd_payload`, `rd_len`, `rd_ts` and `rd_fresh` are valid in that same cycle. Without a strobe, `rd_valid` is low in the next cycle.
- R3: A completed message replaces the held one, including when messages are sent back to back. Byte k of the message (k = 0 first) appears at `rd_payload[8k+7:8k]`, and `rd_len` equals the number of bytes stored.
- R4: Reading is non-destructive. Repeated reads with no message completing between them return identical payload, length and time stamp.
- R5: The time counter is 0 during reset and advances by one on every clock edge after reset. The stored time stamp is the counter value in the cycle in which the byte flagged `wr_last` is accepted.
- R6: `rd_fresh` is 1 exactly when a message is held and (counter value in the strobe cycle − stored time stamp) ≤ `refresh_per`. The boundary where the age equals the period counts as fresh.
- R7: The age is computed modulo 2^TS_W, so a message stamped shortly before the counter wraps is judged by its true distance in ticks.
- R8: While a message is only partly written, reads return the previous complete message unchanged.
- R9: A read strobe in the same cycle as the accepted final byte returns the previous message. The next read returns the new one.
- R10: Bytes beyond NBYTES in one message are discarded, and `rd_len` saturates at NBYTES while the first NBYTES bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A message byte is offered this cycle |
| wr_byte | input | 8 | Message byte |
| wr_last | input | 1 | Offered byte ends the message |
| refresh_per | input | TS_W | Largest age, in ticks, still judged fresh |
| rd_req | input | 1 | Read strobe |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_payload | output | 8*NBYTES | Payload, byte 0 in the low bits |
| rd_len | output | clog2(NBYTES+1) | Number of stored bytes |
| rd_ts | output | TS_W | Time stamp of the held message |
| rd_fresh | output | 1 | Held message is no older than the refresh period |

## Verification
The hardest cases to reach are reads that meet a message in transit. In one, a read lands while the producer is halfway through a message. In the other, the read strobe falls in the very cycle the last byte is accepted. The bench parks the producer with `wr_valid` low after a few bytes and reads in that gap. It also raises the read strobe together with the final byte, then compares both results against the earlier message. The counter wrap is reached by building the bench with a narrow counter, waiting for a chosen count just below the wrap, stamping a message there and reading after the roll-over with periods on both sides of the true age.

// File: rtl/spp_pkg.sv
package spp_pkg;
    parameter int unsigned SPP_BYTES_DEF = 8;
    parameter int unsigned SPP_TS_W_DEF  = 16;
    localparam int unsigned BYTE_W       = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spp_timebase.sv
module spp_timebase #(
    parameter int unsigned TS_W = spp_pkg::SPP_TS_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    logic [TS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + TS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign now = cnt_q;
endmodule

// File: rtl/spp_bank_store.sv
module spp_bank_store #(
    parameter int unsigned NBYTES = spp_pkg::SPP_BYTES_DEF,
    parameter int unsigned TS_W   = spp_pkg::SPP_TS_W_DEF,
    localparam int unsigned LEN_W = $clog2(NBYTES + 1),
    localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int unsigned PAY_W = spp_pkg::BYTE_W * NBYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [spp_pkg::BYTE_W-1:0] wr_byte,
    input  logic                      wr_last,
    input  logic [TS_W-1:0]           ts_now,
    output logic [PAY_W-1:0]          cur_payload,
    output logic [LEN_W-1:0]          cur_len,
    output logic [TS_W-1:0]           cur_ts,
    output logic                      cur_loaded
);
    typedef struct packed {
        logic [1:0][NBYTES-1:0][spp_pkg::BYTE_W-1:0] data;
        logic [1:0][LEN_W-1:0]                       len;
        logic [1:0][TS_W-1:0]                        ts;
        logic                                        sel;
        logic [LEN_W-1:0]                            idx;
        logic                                        loaded;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        logic             fill;
        logic             room;
        logic [LEN_W-1:0] count;
        st_d  = st_q;
        fill  = ~st_q.sel;
        room  = (st_q.idx < LEN_W'(NBYTES));
        count = room ? st_q.idx + LEN_W'(1) : st_q.idx;
        if (wr_valid) begin
            if (room) st_d.data[fill][st_q.idx[IDX_W-1:0]] = wr_byte;
            if (wr_last) begin
                st_d.len[fill] = count;
                st_d.ts[fill]  = ts_now;
                st_d.sel       = fill;
                st_d.loaded    = 1'b1;
                st_d.idx       = '0;
            end else begin
                st_d.idx = count;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign cur_payload[g*spp_pkg::BYTE_W +: spp_pkg::BYTE_W] = st_q.data[st_q.sel][g];
    end

    assign cur_len    = st_q.len[st_q.sel];
    assign cur_ts     = st_q.ts[st_q.sel];
    assign cur_loaded = st_q.loaded;
endmodule

// File: rtl/spp_fresh_eval.sv
module spp_fresh_eval #(
    parameter int unsigned TS_W = spp_pkg::SPP_TS_W_DEF
) (
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] stamp,
    input  logic [TS_W-1:0] period,
    input  logic            loaded,
    output logic            fresh
);
    logic [TS_W-1:0] age;

    always_comb begin
        age   = now - stamp;
        fresh = loaded && (age <= period);
    end
endmodule

// File: rtl/sampling_port_buf.sv
module sampling_port_buf #(
    parameter int unsigned NBYTES = spp_pkg::SPP_BYTES_DEF,
    parameter int unsigned TS_W   = spp_pkg::SPP_TS_W_DEF,
    localparam int unsigned LEN_W = $clog2(NBYTES + 1),
    localparam int unsigned PAY_W = spp_pkg::BYTE_W * NBYTES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [spp_pkg::BYTE_W-1:0] wr_byte,
    input  logic                       wr_last,
    input  logic [TS_W-1:0]            refresh_per,
    input  logic                       rd_req,
    output logic                       rd_valid,
    output logic [PAY_W-1:0]           rd_payload,
    output logic [LEN_W-1:0]           rd_len,
    output logic [TS_W-1:0]            rd_ts,
    output logic                       rd_fresh
);
    logic [TS_W-1:0]  now;
    logic [PAY_W-1:0] cur_payload;
    logic [LEN_W-1:0] cur_len;
    logic [TS_W-1:0]  cur_ts;
    logic             cur_loaded;
    logic             cur_fresh;

    spp_timebase #(.TS_W(TS_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    spp_bank_store #(.NBYTES(NBYTES), .TS_W(TS_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_byte     (wr_byte),
        .wr_last     (wr_last),
        .ts_now      (now),
        .cur_payload (cur_payload),
        .cur_len     (cur_len),
        .cur_ts      (cur_ts),
        .cur_loaded  (cur_loaded)
    );

    spp_fresh_eval #(.TS_W(TS_W)) u_fresh (
        .now    (now),
        .stamp  (cur_ts),
        .period (refresh_per),
        .loaded (cur_loaded),
        .fresh  (cur_fresh)
    );

    typedef struct packed {
        logic             valid;
        logic [PAY_W-1:0] payload;
        logic [LEN_W-1:0] len;
        logic [TS_W-1:0]  ts;
        logic             fresh;
    } rdout_t;

    rdout_t ro_d, ro_q;

    always_comb begin
        ro_d       = ro_q;
        ro_d.valid = rd_req;
        if (rd_req) begin
            ro_d.payload = cur_payload;
            ro_d.len     = cur_len;
            ro_d.ts      = cur_ts;
            ro_d.fresh   = cur_fresh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ro_q <= '0;
        else        ro_q <= ro_d;
    end

    assign rd_valid   = ro_q.valid;
    assign rd_payload = ro_q.payload;
    assign rd_len     = ro_q.len;
    assign rd_ts      = ro_q.ts;
    assign rd_fresh   = ro_q.fresh;
endmodule

// File: rtl/spp_port_chk.sv
module spp_port_chk #(
    parameter int unsigned NBYTES = spp_pkg::SPP_BYTES_DEF,
    parameter int unsigned TS_W   = spp_pkg::SPP_TS_W_DEF,
    localparam int unsigned LEN_W = $clog2(NBYTES + 1),
    localparam int unsigned PAY_W = spp_pkg::BYTE_W * NBYTES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_last,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [PAY_W-1:0] rd_payload,
    input logic [LEN_W-1:0] rd_len,
    input logic [TS_W-1:0]  rd_ts,
    input logic             rd_fresh
);
    // R2: strobe produces a result in the next cycle
    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R2: no strobe, no result
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R10: stored length never exceeds capacity
    p_len_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_len <= LEN_W'(NBYTES)));

    // R1: an empty port is never reported fresh
    p_empty_stale_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_len == '0) |-> !rd_fresh);

    // R4: back-to-back reads with no completed write between return the same message
    p_reread_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && !$past(wr_valid && wr_last, 2))
        |-> ($stable(rd_len) && $stable(rd_ts) && $stable(rd_payload)));
endmodule

bind sampling_port_buf spp_port_chk #(.NBYTES(NBYTES), .TS_W(TS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_last    (wr_last),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_payload (rd_payload),
    .rd_len     (rd_len),
    .rd_ts      (rd_ts),
    .rd_fresh   (rd_fresh)
);

// File: tb/sampling_port_buf_tb.sv
module sampling_port_buf_tb;
    localparam int NB   = 4;
    localparam int TSW  = 8;
    localparam int LENW = $clog2(NB + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_valid = 1'b0;
    logic [7:0]      wr_byte = '0;
    logic            wr_last = 1'b0;
    logic [TSW-1:0]  refresh_per = '0;
    logic            rd_req = 1'b0;
    logic            rd_valid;
    logic [8*NB-1:0] rd_payload;
    logic [LENW-1:0] rd_len;
    logic [TSW-1:0]  rd_ts;
    logic            rd_fresh;

    sampling_port_buf #(.NBYTES(NB), .TS_W(TSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .wr_last(wr_last), .refresh_per(refresh_per), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_payload(rd_payload), .rd_len(rd_len),
        .rd_ts(rd_ts), .rd_fresh(rd_fresh)
    );

    always #5 clk = ~clk;

    // reference time: 0 in reset, +1 per edge afterwards
    logic [TSW-1:0] tb_t;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_t <= '0;
        else        tb_t <= tb_t + 8'd1;
    end

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model of the held message and the one in transit
    logic [7:0]     m_b [NB];
    int             m_len  = 0;
    logic [TSW-1:0] m_ts   = '0;
    bit             m_have = 0;
    logic [7:0]     p_b [NB];
    int             p_cnt  = 0;
    logic [TSW-1:0] last_tnow;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_byte  = b;
        wr_last  = last;
        if (p_cnt < NB) begin
            p_b[p_cnt] = b;
            p_cnt++;
        end
        if (last) begin
            for (int k = 0; k < NB; k++) m_b[k] = p_b[k];
            m_len  = p_cnt;
            m_ts   = tb_t;
            m_have = 1;
            p_cnt  = 0;
        end
    endtask

    task automatic release_wr();
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    // compare the visible result against a snapshot of the model
    task automatic compare(input string req, input logic [7:0] eb [NB], input int elen,
                           input logic [TSW-1:0] ets, input bit efresh);
        check(req, "rd_valid", 64'(rd_valid), 64'd1);
        check(req, "rd_len", 64'(rd_len), 64'(elen));
        check(req, "rd_ts", 64'(rd_ts), 64'(ets));
        check(req, "rd_fresh", 64'(rd_fresh), 64'(efresh));
        for (int k = 0; k < elen; k++)
            check(req, "payload byte", 64'(rd_payload[8*k +: 8]), 64'(eb[k]));
    endtask

    // rel=1: period = true age + arg; rel=0: period = arg
    task automatic do_read(input string req, input bit rel, input int arg);
        logic [TSW-1:0] per;
        logic [TSW-1:0] age;
        logic [7:0]     sb [NB];
        int             slen;
        logic [TSW-1:0] sts;
        bit             sf;
        @(negedge clk);
        last_tnow = tb_t;
        age = tb_t - m_ts;
        per = rel ? TSW'(int'(age) + arg) : TSW'(arg);
        refresh_per = per;
        rd_req = 1'b1;
        for (int k = 0; k < NB; k++) sb[k] = m_b[k];
        slen = m_len;
        sts  = m_ts;
        sf   = m_have && (age <= per);
        @(negedge clk);
        rd_req = 1'b0;
        compare(req, sb, slen, sts, sf);
        @(negedge clk);
        check("R2", "rd_valid drops", 64'(rd_valid), 64'd0);
    endtask

    typedef struct packed {
        logic       rd;
        logic [3:0] n;
        logic [7:0] seed;
        logic [7:0] per;
        logic [3:0] idle;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{1'b0, 4'd3, 8'h10, 8'd0,   4'd1},   // R3 three-byte message
        '{1'b1, 4'd0, 8'h00, 8'd50,  4'd2},   // R5/R6 fresh read
        '{1'b1, 4'd0, 8'h00, 8'd50,  4'd0},   // R4 read again
        '{1'b0, 4'd4, 8'hA0, 8'd0,   4'd0},   // R3 full-size message
        '{1'b0, 4'd1, 8'h55, 8'd0,   4'd0},   // R3 back-to-back one-byte overwrite
        '{1'b1, 4'd0, 8'h00, 8'd0,   4'd3},   // R6 zero period -> stale
        '{1'b1, 4'd0, 8'h00, 8'd200, 4'd0},   // R6 wide period -> fresh
        '{1'b0, 4'd2, 8'hC3, 8'd0,   4'd5}    // R3 two-byte message
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]     ob [NB];
        int             olen;
        logic [TSW-1:0] ots;

        repeat (3) @(negedge clk);
        check("R1", "rd_valid in reset", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_valid after reset", 64'(rd_valid), 64'd0);
        do_read("R1", 0, 255);

        // vector table walk
        for (int i = 0; i < 8; i++) begin
            repeat (int'(VEC[i].idle)) @(negedge clk);
            if (VEC[i].rd) begin
                do_read("R6", 0, int'(VEC[i].per));
            end else begin
                for (int j = 0; j < int'(VEC[i].n); j++)
                    send_byte(VEC[i].seed + 8'(j), j == int'(VEC[i].n) - 1);
                release_wr();
            end
        end
        do_read("R3", 0, 255);
        do_read("R4", 0, 255);

        // R5: stamp equals the count at the final byte
        send_byte(8'h01, 0);
        repeat (3) send_byte(8'h02, 0);
        release_wr();
        repeat (4) @(negedge clk);
        send_byte(8'h03, 1);
        release_wr();
        do_read("R5", 0, 255);

        // R6: inclusive boundary
        repeat (6) @(negedge clk);
        do_read("R6", 1, 0);
        do_read("R6", 1, -1);

        // R10: six bytes into a four-byte port
        for (int j = 0; j < 6; j++) send_byte(8'h60 + 8'(j), j == 5);
        release_wr();
        do_read("R10", 0, 255);

        // R8: reader meets a half-written message
        send_byte(8'h31, 0);
        send_byte(8'h32, 0);
        release_wr();
        repeat (2) @(negedge clk);
        do_read("R8", 0, 255);
        send_byte(8'h33, 1);
        release_wr();
        do_read("R8", 0, 255);

        // R9: strobe in the cycle of the final byte
        for (int k = 0; k < NB; k++) ob[k] = m_b[k];
        olen = m_len;
        ots  = m_ts;
        send_byte(8'h91, 0);
        send_byte(8'h92, 1);
        rd_req = 1'b1;
        refresh_per = 8'hFF;
        @(negedge clk);
        rd_req = 1'b0;
        wr_valid = 1'b0;
        wr_last = 1'b0;
        compare("R9", ob, olen, ots, 1'b1);
        do_read("R9", 0, 255);

        // R7: stamp just before the wrap, read after it
        while (tb_t != 8'd240) @(negedge clk);
        send_byte(8'h77, 1);
        release_wr();
        repeat (25) @(negedge clk);
        do_read("R7", 1, 0);
        check("R7", "counter wrapped", 64'(last_tnow < m_ts), 64'd1);
        do_read("R7", 1, -1);
        do_read("R7", 1, 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule